// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block manages an on-chip packet memory divided into 256-byte pages. It does not hold packet data; it tracks which pages belong to which packet, hands out packet numbers from a small pool, and keeps the three packet-number queues that link the host and the MAC. A host command asks for a transmit buffer of a given page count. After a fixed latency the block either returns a packet number or reports failure. The host polls a done flag to learn which.

After the host has filled an allocated packet, it enqueues that packet for transmit. When the MAC reports a finished transmission, the head of the transmit queue moves to a completion queue and a transmit flag is raised. The host must then free that packet explicitly. Received frames take pages and a number as soon as they arrive and join a receive queue. The host drains that queue with a release command, which also returns the pages. A reset command returns the whole memory to the free pool.

Pages are granted lowest-index first and need not be contiguous. Packet numbers are also granted lowest first.

Top module: `pkt_page_mmu`

## Requirements
- R1: After reset all 18 pages are free, every queue is empty, both flags and the busy output are low, and the allocation result reads 0x80.
- R2: Command codes are 1 allocate, 2 reset, 3 enqueue, 4 free, 5 release; 0, 6 and 7 do nothing. An allocate of 1 to 7 pages grants the lowest-indexed free pages and the lowest free packet number, and the result register then reads {1'b0, packet number}.
- R3: The done flag and the result become valid exactly ALLOC_LAT clock edges after the edge that takes the allocate command. Meanwhile busy is high and result bit 7 stays set.
- R4: An allocate fails if the page count is 0 or above 7, if too few pages are free, or if no packet number is free. On failure result bit 7 stays set, the done flag is not raised, and no pages are consumed.
- R5: Driving ackAlloc high for a cycle clears the done flag. An allocate issued while another allocate is pending is ignored.
- R6: Enqueue appends the packet named by cmdPkt to the transmit queue, in first-in first-out order. A number that is not currently allocated is ignored.
- R7: txComplete moves the transmit queue head to the completion queue and sets txFlag. ackTx clears txFlag, and a new completion in the same cycle wins over the clear.
- R8: Free pops the completion queue head and returns its pages and its number to the pools. Free is ignored when the completion queue is empty.
- R9: rxArrive with rxPages of 1 to 7 grants pages and a number in that cycle and appends the packet to the receive queue. An arrival that cannot be served is dropped. An arrival takes precedence over an allocation finishing in the same cycle, and that allocation then finishes one edge later.
- R10: Release pops the receive queue head and returns its pages and number. Release is ignored when the queue is empty. rxEmpty shows whether the queue is empty.
- R11: The reset command frees all pages and numbers, empties all three queues and cancels a pending allocate. The two flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code |
| cmdPages | input | 4 | Page count for allocate |
| cmdPkt | input | 7 | Packet number for enqueue |
| ackAlloc | input | 1 | Clears the allocation done flag |
| ackTx | input | 1 | Clears the transmit flag |
| txComplete | input | 1 | MAC finished the transmit queue head |
| rxArrive | input | 1 | A received frame needs storage |
| rxPages | input | 4 | Page count of the received frame |
| allocResult | output | 8 | Bit 7 fail/pending, bits 6:0 packet number |
| allocBusy | output | 1 | Allocation in progress |
| allocFlag | output | 1 | Allocation done flag |
| txFlag | output | 1 | Transmit completion flag |
| txHeadValid | output | 1 | Transmit queue not empty |
| txHeadPkt | output | 7 | Transmit queue head |
| cmplEmpty | output | 1 | Completion queue empty |
| cmplPkt | output | 7 | Completion queue head |
| rxEmpty | output | 1 | Receive queue empty |
| rxHeadPkt | output | 7 | Receive queue head |
| freePageCnt | output | 5 | Number of free pages |

## Verification
The bench targets the following corner cases and the failures they expose:

- **Completion timing.** The done flag is checked in the cycle before and the cycle of completion. An off-by-one latency counter would raise it early or late.
- **Rejected allocations.** Page counts of 0 and 8 are tried, as are a request larger than the free space and a request when the number pool is exhausted. A design that granted a partial buffer would show a lower free count, and one that set the flag on failure would show the flag high.
- **Ignored commands.** A second allocate while one is pending, an enqueue of an unallocated number, and free and release on empty queues are all issued. A design that accepted any of them would change the free count or the queue heads.
- **Same-cycle conflict and reset.** A receive arrival is placed in the exact cycle an allocation would finish, and the bench checks that the allocation slips by one edge and takes the next packet number. A reset is issued behind a pending allocate, and the bench checks that no late completion follows.

// File: rtl/pkt_mmu_pkg.sv
package pkt_mmu_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_ENQ     = 3'd3,
    OP_FREE    = 3'd4,
    OP_RELEASE = 3'd5
  } mmuOp_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;
    logic allocTry;
    logic rxTry;
    logic enq;
    logic txPop;
    logic freeHead;
    logic relHead;
  } mmuStrobe_t;

endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= din;
        wrPtr <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pkt_mmu_ctrl.sv
module pkt_mmu_ctrl
  import pkt_mmu_pkg::*;
#(
  parameter int ALLOC_LAT = 3,
  parameter int PKT_W     = 7,
  parameter int REQ_W     = 4,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [REQ_W-1:0] cmdPages,
  input  logic             ackAlloc,
  input  logic             ackTx,
  input  logic             txComplete,
  input  logic             rxArrive,
  input  logic             dpAllocOk,
  input  logic [IDX_W-1:0] dpAllocPkt,
  input  logic             dpTxAvail,
  output mmuStrobe_t       strobe,
  output logic [REQ_W-1:0] reqPages,
  output logic [PKT_W:0]   allocResult,
  output logic             allocBusy,
  output logic             allocFlag,
  output logic             txFlag
);
  localparam int LAT_W = $clog2(ALLOC_LAT + 1);

  logic pending;
  logic [LAT_W-1:0] latCnt;
  logic isAlloc;

  assign isAlloc = cmdValid && (cmdOp == OP_ALLOC);

  always_comb begin
    strobe.clear    = cmdValid && (cmdOp == OP_RESET);
    strobe.allocTry = pending && (latCnt == '0) && !rxArrive && !strobe.clear;
    strobe.rxTry    = rxArrive && !strobe.clear;
    strobe.enq      = cmdValid && (cmdOp == OP_ENQ);
    strobe.txPop    = txComplete && !strobe.clear;
    strobe.freeHead = cmdValid && (cmdOp == OP_FREE);
    strobe.relHead  = cmdValid && (cmdOp == OP_RELEASE);
  end

  assign allocBusy = pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending     <= 1'b0;
      latCnt      <= '0;
      reqPages    <= '0;
      allocResult <= {1'b1, {PKT_W{1'b0}}};
      allocFlag   <= 1'b0;
      txFlag      <= 1'b0;
    end else begin
      if (strobe.clear) begin
        pending <= 1'b0;
      end else if (isAlloc && !pending) begin
        pending     <= 1'b1;
        latCnt      <= LAT_W'(ALLOC_LAT - 1);
        reqPages    <= cmdPages;
        allocResult <= {1'b1, {PKT_W{1'b0}}};
      end else if (strobe.allocTry) begin
        pending <= 1'b0;
        if (dpAllocOk) allocResult <= {1'b0, PKT_W'(dpAllocPkt)};
      end else if (pending && latCnt != '0) begin
        latCnt <= latCnt - 1'b1;
      end

      if (strobe.allocTry && dpAllocOk) allocFlag <= 1'b1;
      else if (ackAlloc)                allocFlag <= 1'b0;

      if (strobe.txPop && dpTxAvail) txFlag <= 1'b1;
      else if (ackTx)                txFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/pkt_mmu_dp.sv
module pkt_mmu_dp
  import pkt_mmu_pkg::*;
#(
  parameter int NUM_PAGES = 18,
  parameter int NUM_PKTS  = 8,
  parameter int MAX_PAGES = 7,
  parameter int PKT_W     = 7,
  parameter int REQ_W     = 4,
  parameter int IDX_W     = $clog2(NUM_PKTS),
  parameter int CNT_W     = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  mmuStrobe_t       strobe,
  input  logic [REQ_W-1:0] reqPages,
  input  logic [REQ_W-1:0] rxPages,
  input  logic [PKT_W-1:0] cmdPkt,
  output logic             allocOk,
  output logic [IDX_W-1:0] allocPkt,
  output logic             txAvail,
  output logic [PKT_W-1:0] txHeadPkt,
  output logic             cmplEmpty,
  output logic [PKT_W-1:0] cmplPkt,
  output logic             rxEmpty,
  output logic [PKT_W-1:0] rxHeadPkt,
  output logic [CNT_W-1:0] freePageCnt
);
  logic [NUM_PAGES-1:0] pageUsed, grant, retMask;
  logic [NUM_PKTS-1:0]  pktUsed, retPkt, selHot;
  logic [NUM_PAGES-1:0] pktMask [NUM_PKTS];
  logic [REQ_W-1:0] need;
  logic pktFound, commit, enqOk, txPop, freeFire, relFire, txEmpty, txFull, cmplFull, rxFull;
  logic [IDX_W-1:0] cmdIdx, txHead, cmplHead, rxHead;
  int taken;

  // lowest-first page and number chooser
  always_comb begin
    need  = strobe.rxTry ? rxPages : reqPages;
    grant = '0;
    taken = 0;
    for (int i = 0; i < NUM_PAGES; i++) begin
      if (!pageUsed[i] && taken < int'(need)) begin
        grant[i] = 1'b1;
        taken    = taken + 1;
      end
    end
    pktFound = 1'b0;
    allocPkt = '0;
    for (int j = NUM_PKTS - 1; j >= 0; j--) begin
      if (!pktUsed[j]) begin
        pktFound = 1'b1;
        allocPkt = IDX_W'(j);
      end
    end
    allocOk = pktFound && (need != '0) && (int'(need) <= MAX_PAGES) && (taken == int'(need));
  end

  assign commit   = allocOk && (strobe.allocTry || strobe.rxTry);
  assign selHot   = commit ? (NUM_PKTS'(1) << allocPkt) : '0;
  assign cmdIdx   = cmdPkt[IDX_W-1:0];
  assign enqOk    = strobe.enq && (cmdPkt < PKT_W'(NUM_PKTS)) && pktUsed[cmdIdx];
  assign txAvail  = !txEmpty;
  assign txPop    = strobe.txPop && txAvail;
  assign freeFire = strobe.freeHead && !cmplEmpty;
  assign relFire  = strobe.relHead && !rxEmpty;

  assign retMask = (relFire ? pktMask[rxHead] : '0) | (freeFire ? pktMask[cmplHead] : '0);
  assign retPkt  = (relFire ? (NUM_PKTS'(1) << rxHead) : '0) |
                   (freeFire ? (NUM_PKTS'(1) << cmplHead) : '0);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      pageUsed <= '0;
      pktUsed  <= '0;
    end else begin
      pageUsed <= (pageUsed & ~retMask) | (commit ? grant : '0);
      pktUsed  <= (pktUsed & ~retPkt) | selHot;
      if (commit) pktMask[allocPkt] <= grant;
    end
  end

  always_comb begin
    freePageCnt = '0;
    for (int k = 0; k < NUM_PAGES; k++)
      if (!pageUsed[k]) freePageCnt = freePageCnt + 1'b1;
  end

  pkt_fifo #(.DEPTH(NUM_PKTS), .WIDTH(IDX_W)) uTxQ (
    .clk(clk), .rstN(rstN), .clr(strobe.clear), .push(enqOk), .din(cmdIdx),
    .pop(txPop), .dout(txHead), .empty(txEmpty), .full(txFull));

  pkt_fifo #(.DEPTH(NUM_PKTS), .WIDTH(IDX_W)) uCmplQ (
    .clk(clk), .rstN(rstN), .clr(strobe.clear), .push(txPop), .din(txHead),
    .pop(freeFire), .dout(cmplHead), .empty(cmplEmpty), .full(cmplFull));

  pkt_fifo #(.DEPTH(NUM_PKTS), .WIDTH(IDX_W)) uRxQ (
    .clk(clk), .rstN(rstN), .clr(strobe.clear), .push(strobe.rxTry && allocOk),
    .din(allocPkt), .pop(relFire), .dout(rxHead), .empty(rxEmpty), .full(rxFull));

  assign txHeadPkt = PKT_W'(txHead);
  assign cmplPkt   = PKT_W'(cmplHead);
  assign rxHeadPkt = PKT_W'(rxHead);

  logic unusedFull;
  assign unusedFull = txFull ^ cmplFull ^ rxFull;
endmodule

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu
  import pkt_mmu_pkg::*;
#(
  parameter int NUM_PAGES = 18,
  parameter int NUM_PKTS  = 8,
  parameter int MAX_PAGES = 7,
  parameter int ALLOC_LAT = 3,
  parameter int PKT_W     = 7,
  parameter int REQ_W     = 4,
  parameter int CNT_W     = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [REQ_W-1:0] cmdPages,
  input  logic [PKT_W-1:0] cmdPkt,
  input  logic             ackAlloc,
  input  logic             ackTx,
  input  logic             txComplete,
  input  logic             rxArrive,
  input  logic [REQ_W-1:0] rxPages,
  output logic [PKT_W:0]   allocResult,
  output logic             allocBusy,
  output logic             allocFlag,
  output logic             txFlag,
  output logic             txHeadValid,
  output logic [PKT_W-1:0] txHeadPkt,
  output logic             cmplEmpty,
  output logic [PKT_W-1:0] cmplPkt,
  output logic             rxEmpty,
  output logic [PKT_W-1:0] rxHeadPkt,
  output logic [CNT_W-1:0] freePageCnt
);
  localparam int IDX_W = $clog2(NUM_PKTS);

  mmuStrobe_t strobe;
  logic [REQ_W-1:0] reqPages;
  logic dpAllocOk;
  logic [IDX_W-1:0] dpAllocPkt;

  pkt_mmu_ctrl #(.ALLOC_LAT(ALLOC_LAT), .PKT_W(PKT_W), .REQ_W(REQ_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPages(cmdPages),
    .ackAlloc(ackAlloc), .ackTx(ackTx), .txComplete(txComplete), .rxArrive(rxArrive),
    .dpAllocOk(dpAllocOk), .dpAllocPkt(dpAllocPkt), .dpTxAvail(txHeadValid),
    .strobe(strobe), .reqPages(reqPages), .allocResult(allocResult),
    .allocBusy(allocBusy), .allocFlag(allocFlag), .txFlag(txFlag));

  pkt_mmu_dp #(.NUM_PAGES(NUM_PAGES), .NUM_PKTS(NUM_PKTS), .MAX_PAGES(MAX_PAGES),
               .PKT_W(PKT_W), .REQ_W(REQ_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqPages(reqPages), .rxPages(rxPages),
    .cmdPkt(cmdPkt), .allocOk(dpAllocOk), .allocPkt(dpAllocPkt), .txAvail(txHeadValid),
    .txHeadPkt(txHeadPkt), .cmplEmpty(cmplEmpty), .cmplPkt(cmplPkt), .rxEmpty(rxEmpty),
    .rxHeadPkt(rxHeadPkt), .freePageCnt(freePageCnt));
endmodule

// File: rtl/pkt_page_mmu_chk.sv
module pkt_page_mmu_chk #(
  parameter int NUM_PAGES = 18,
  parameter int PKT_W     = 7,
  parameter int REQ_W     = 4,
  parameter int CNT_W     = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [2:0]       cmdOp,
  input logic [REQ_W-1:0] cmdPages,
  input logic [PKT_W-1:0] cmdPkt,
  input logic             ackAlloc,
  input logic             ackTx,
  input logic             txComplete,
  input logic             rxArrive,
  input logic [REQ_W-1:0] rxPages,
  input logic [PKT_W:0]   allocResult,
  input logic             allocBusy,
  input logic             allocFlag,
  input logic             txFlag,
  input logic             txHeadValid,
  input logic [PKT_W-1:0] txHeadPkt,
  input logic             cmplEmpty,
  input logic [PKT_W-1:0] cmplPkt,
  input logic             rxEmpty,
  input logic [PKT_W-1:0] rxHeadPkt,
  input logic [CNT_W-1:0] freePageCnt
);
  logic isReset, isRelease;
  assign isReset   = cmdValid && (cmdOp == 3'd2);
  assign isRelease = cmdValid && (cmdOp == 3'd5);

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    freePageCnt <= CNT_W'(NUM_PAGES)); // R2
  AST_BUSY_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    allocBusy |-> allocResult[PKT_W]); // R3
  AST_FLAG_SUCCESS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(allocFlag) |-> (!allocResult[PKT_W] && !allocBusy)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackAlloc && !allocBusy) |=> !allocFlag); // R5
  AST_TX_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (txComplete && txHeadValid && !isReset) |=> txFlag); // R7
  AST_RX_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEmpty && !isReset && !isRelease) |=> (!rxEmpty && $stable(rxHeadPkt))); // R10
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    isReset |=> (freePageCnt == CNT_W'(NUM_PAGES) && rxEmpty && cmplEmpty &&
                 !txHeadValid && !allocBusy)); // R11
endmodule

bind pkt_page_mmu pkt_page_mmu_chk #(.NUM_PAGES(NUM_PAGES), .PKT_W(PKT_W),
  .REQ_W(REQ_W), .CNT_W(CNT_W)) uChk (.*);

// File: tb/tb_pkt_page_mmu.sv
module tb_pkt_page_mmu;
  localparam int LAT = 3;
  localparam logic [2:0] C_ALLOC = 3'd1, C_RESET = 3'd2, C_ENQ = 3'd3, C_FREE = 3'd4, C_REL = 3'd5;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, ackAlloc = 1'b0, ackTx = 1'b0, txComplete = 1'b0, rxArrive = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [3:0] cmdPages = '0, rxPages = '0;
  logic [6:0] cmdPkt = '0;
  logic [7:0] allocResult;
  logic allocBusy, allocFlag, txFlag, txHeadValid, cmplEmpty, rxEmpty;
  logic [6:0] txHeadPkt, cmplPkt, rxHeadPkt;
  logic [4:0] freePageCnt;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pkt_page_mmu #(.ALLOC_LAT(LAT)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [3:0] pg, input logic [6:0] pk);
    cmdValid = 1'b1; cmdOp = op; cmdPages = pg; cmdPkt = pk;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = '0;
  endtask

  task automatic ackA();
    ackAlloc = 1'b1; @(negedge clk); ackAlloc = 1'b0;
    chk("R5 flag cleared", int'(allocFlag), 0);
  endtask

  task automatic rxPulse(input logic [3:0] pg);
    rxArrive = 1'b1; rxPages = pg; @(negedge clk); rxArrive = 1'b0;
  endtask

  task automatic txPulse();
    txComplete = 1'b1; @(negedge clk); txComplete = 1'b0;
  endtask

  task automatic doAlloc(input logic [3:0] pg, input bit ok, input int pkt, input int free);
    cmd(C_ALLOC, pg, 0);
    chk("R3 busy", int'(allocBusy), 1);
    chk("R3 pending result", int'(allocResult), 8'h80);
    repeat (LAT - 1) @(negedge clk);
    chk("R3 flag not early", int'(allocFlag), 0);
    @(negedge clk);
    chk(ok ? "R2 flag" : "R4 no flag", int'(allocFlag), int'(ok));
    chk(ok ? "R2 result" : "R4 result", int'(allocResult), ok ? pkt : 8'h80);
    chk(ok ? "R2 free pages" : "R4 pages kept", int'(freePageCnt), free);
    if (ok) ackA();
  endtask

  task automatic testReset();
    chk("R1 free", int'(freePageCnt), 18);
    chk("R1 rxEmpty", int'(rxEmpty), 1);
    chk("R1 cmplEmpty", int'(cmplEmpty), 1);
    chk("R1 tx queue", int'(txHeadValid), 0);
    chk("R1 flags", int'({allocFlag, txFlag, allocBusy}), 0);
    chk("R1 result", int'(allocResult), 8'h80);
  endtask

  task automatic testAlloc();
    doAlloc(3, 1, 0, 15);
    doAlloc(4, 1, 1, 11);
    doAlloc(8, 0, 0, 11);
    doAlloc(0, 0, 0, 11);
    doAlloc(7, 1, 2, 4);
    doAlloc(5, 0, 0, 4);
    cmd(C_ALLOC, 1, 0);
    cmd(C_ALLOC, 2, 0);  // ignored, one is pending
    repeat (LAT - 1) @(negedge clk);
    chk("R5 first alloc done", int'(allocResult), 3);
    chk("R5 second ignored", int'(freePageCnt), 3);
    ackA();
  endtask

  task automatic testTx();
    cmd(C_ENQ, 0, 1);
    cmd(C_ENQ, 0, 0);
    cmd(C_ENQ, 0, 5);  // never allocated
    chk("R6 head valid", int'(txHeadValid), 1);
    chk("R6 head order", int'(txHeadPkt), 1);
    txPulse();
    chk("R7 flag set", int'(txFlag), 1);
    chk("R7 next head", int'(txHeadPkt), 0);
    chk("R7 completion head", int'(cmplPkt), 1);
    ackTx = 1'b1; @(negedge clk); ackTx = 1'b0;
    chk("R7 flag cleared", int'(txFlag), 0);
    txPulse();
    chk("R6 unallocated ignored", int'(txHeadValid), 0);
    cmd(C_FREE, 0, 0);
    chk("R8 pages back", int'(freePageCnt), 7);
    chk("R8 next completion", int'(cmplPkt), 0);
    cmd(C_FREE, 0, 0);
    chk("R8 pages back 2", int'(freePageCnt), 10);
    chk("R8 queue empty", int'(cmplEmpty), 1);
    cmd(C_FREE, 0, 0);
    chk("R8 free on empty ignored", int'(freePageCnt), 10);
  endtask

  task automatic testRx();
    rxPulse(2);
    chk("R9 rx queued", int'(rxEmpty), 0);
    chk("R9 rx number", int'(rxHeadPkt), 0);
    chk("R9 rx pages", int'(freePageCnt), 8);
    rxPulse(9);
    chk("R9 oversize dropped", int'(freePageCnt), 8);
    cmd(C_REL, 0, 0);
    chk("R10 empty after release", int'(rxEmpty), 1);
    chk("R10 pages back", int'(freePageCnt), 10);
    cmd(C_REL, 0, 0);
    chk("R10 release on empty ignored", int'(freePageCnt), 10);
  endtask

  task automatic testConflict();
    cmd(C_ALLOC, 2, 0);
    repeat (LAT - 1) @(negedge clk);
    rxPulse(1);  // sampled on the edge the allocate would finish
    chk("R9 alloc slips", int'(allocFlag), 0);
    chk("R9 rx first number", int'(rxHeadPkt), 0);
    chk("R9 rx pages", int'(freePageCnt), 9);
    @(negedge clk);
    chk("R9 alloc done late", int'(allocFlag), 1);
    chk("R9 alloc next number", int'(allocResult), 1);
    chk("R9 pages", int'(freePageCnt), 7);
    ackA();
  endtask

  task automatic testResetCmd();
    cmd(C_ENQ, 0, 1);
    txPulse();
    cmd(C_ENQ, 0, 2);
    cmd(C_RESET, 0, 0);
    chk("R11 pages", int'(freePageCnt), 18);
    chk("R11 queues", int'({txHeadValid, cmplEmpty, rxEmpty}), 3);
    chk("R11 flag kept", int'(txFlag), 1);
    ackTx = 1'b1; @(negedge clk); ackTx = 1'b0;
    cmd(C_ALLOC, 1, 0);
    cmd(C_RESET, 0, 0);
    chk("R11 cancel busy", int'(allocBusy), 0);
    repeat (LAT + 1) @(negedge clk);
    chk("R11 no late flag", int'(allocFlag), 0);
    chk("R11 no late pages", int'(freePageCnt), 18);
  endtask

  task automatic testNoNumber();
    for (int i = 0; i < 8; i++) rxPulse(1);
    chk("R9 eight rx", int'(freePageCnt), 10);
    doAlloc(1, 0, 0, 10);
    rxPulse(1);
    chk("R9 no number dropped", int'(freePageCnt), 10);
    cmd(C_REL, 0, 0);
    chk("R10 head advances", int'(rxHeadPkt), 1);
    chk("R10 page back", int'(freePageCnt), 11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAlloc();
    testTx();
    testRx();
    testConflict();
    testResetCmd();
    testNoNumber();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule